// File: doc/BRIEF.md
# Sequential-Access Serial Configuration Target

This block is a receive-side I2C target holding six configuration bytes for a clock synthesiser. A controller sets the bytes with a block write. The address byte comes first. Two bytes follow that the target acknowledges and then throws away. After those, each byte goes into the next register, starting at register 0. There is no offset field, so every access begins at register 0 and moves upward one register per byte.

A block read begins with the target sending the number of registers it holds. It then sends register 0, register 1 and so on until the controller refuses a byte or ends the transfer. The register contents are also driven as one flat parallel bus, so the clock-generation logic can use them directly.

SCL and SDA are brought into the system clock domain through two-stage synchronisers. START and STOP are recognised as SDA edges while SCL is high. SDA is driven open-drain: `sda_oe` high means the pad is pulled low.

Top module: `cfgi2c_slave`

## Requirements
- R1: The target responds only to 7-bit address 0x69, which gives address byte 0xD2 for writes and 0xD3 for reads. Any other address is not acknowledged, the target does not drive SDA, and the rest of that transfer has no effect.
- R2: In a write, the two bytes after the address byte are acknowledged and their contents are not stored.
- R3: From the third byte after the address onward, each written byte is stored in register 0, 1, 2, … in ascending order. Register k appears on `cfg_o[8k+7:8k]`.
- R4: A STOP after any complete byte ends the write. Registers written so far keep their new values, and the other registers are unchanged.
- R5: Bytes written past register 5 are acknowledged and discarded.
- R6: After reset, register 0 reads 0x00 and registers 1 to 5 read 0xFF.
- R7: In a read, the first byte sent is the register count, 0x06. It is followed by register 0, 1, 2, … with the most significant bit first.
- R8: Once register 5 has been sent, every further byte in the same read repeats register 5.
- R9: When the controller does not acknowledge a read byte, the target releases SDA. It does not drive SDA again until the next START.
- R10: The target pulls SDA low during the acknowledge bit of every byte it accepts.
- R11: The target never starts pulling SDA low while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| cfg_o | output | 48 | Register contents, register k in bits 8k+7:8k |

## Verification
Two cases are hard to reach from the ports. The first is the read pointer parking on the last register. Getting there takes a read that runs past all six registers, so the controller must acknowledge two more bytes than the target holds. The second is the quiet state after a refused byte. The bench sends a NACK and then keeps clocking a full byte with no new START, expecting all ones on the line. Writes that overrun the register file, and writes that stop after two registers, are entries in the vector table. An expected-register model is updated from the table alongside them.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SACK,
    ST_WR,
    ST_RD,
    ST_MACK
  } cfgi2c_st_e;
endpackage

// File: rtl/cfgi2c_sync.sv
module cfgi2c_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic rst_sync_n,
  output logic scl_s,
  output logic sda_s
);
  logic [1:0] rst_pipe;
  logic [1:0] scl_pipe;
  logic [1:0] sda_pipe;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      scl_pipe <= 2'b11;
      sda_pipe <= 2'b11;
    end else begin
      scl_pipe <= {scl_pipe[0], scl_i};
      sda_pipe <= {sda_pipe[0], sda_i};
    end
  end
  assign scl_s = scl_pipe[1];
  assign sda_s = sda_pipe[1];
endmodule

// File: rtl/cfgi2c_regs.sv
module cfgi2c_regs #(
  parameter int NUM_REGS = 6,
  localparam int IDXW = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [IDXW-1:0]       widx_i,
  input  logic [7:0]            wdata_i,
  output logic [NUM_REGS*8-1:0] q_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    localparam logic [7:0] RST_VAL = (k == 0) ? 8'h00 : 8'hFF;
    logic [7:0] val_q;
    logic       hit;
    assign hit = we_i && (widx_i == IDXW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= RST_VAL;
      else if (hit) val_q <= wdata_i;
    end
    assign q_o[8*k +: 8] = val_q;
  end

  // R5
  wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> (int'(widx_i) < NUM_REGS));
endmodule

// File: rtl/cfgi2c_slave.sv
module cfgi2c_slave
  import cfgi2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 6,
  parameter int         DUMMY_BYTES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  localparam int IDXW = $clog2(NUM_REGS);
  localparam int WCW  = $clog2(NUM_REGS + DUMMY_BYTES + 1);
  localparam logic [WCW-1:0]  WC_DUM  = WCW'(DUMMY_BYTES);
  localparam logic [WCW-1:0]  WC_MAX  = WCW'(DUMMY_BYTES + NUM_REGS);
  localparam logic [IDXW-1:0] IDX_LST = IDXW'(NUM_REGS - 1);
  localparam logic [7:0]      CNT_BYTE = 8'(NUM_REGS);

  logic rst_s_n, scl_s, sda_s, scl_d, sda_d;
  logic scl_rise, scl_fall, bus_start, bus_stop;

  cfgi2c_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .rst_sync_n(rst_s_n), .scl_s(scl_s), .sda_s(sda_s)
  );

  cfgi2c_st_e         st_q, st_d;
  logic [3:0]         bit_q, bit_d;
  logic [7:0]         sh_q, sh_d, tx_q, tx_d;
  logic               oe_q, oe_d, rw_q, rw_d, aack_q, aack_d, mack_q, mack_d;
  logic [WCW-1:0]     wcnt_q, wcnt_d, wrel;
  logic [IDXW-1:0]    ridx_q, ridx_d;
  logic               we;
  logic [7:0]         rd_byte;

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
  assign wrel      = wcnt_q - WC_DUM;
  assign rd_byte   = cfg_o[{ridx_q, 3'b000} +: 8];

  always_comb begin
    st_d = st_q; bit_d = bit_q; sh_d = sh_q; tx_d = tx_q; oe_d = oe_q;
    rw_d = rw_q; aack_d = aack_q; mack_d = mack_q; wcnt_d = wcnt_q;
    ridx_d = ridx_q; we = 1'b0;
    if (bus_start) begin
      st_d = ST_ADDR; bit_d = 4'd0; oe_d = 1'b0;
    end else if (bus_stop) begin
      st_d = ST_IDLE; oe_d = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d = {sh_q[6:0], sda_s}; bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            if (sh_q[7:1] == DEV_ADDR) begin
              st_d = ST_SACK; oe_d = 1'b1; rw_d = sh_q[0]; aack_d = 1'b1;
              wcnt_d = '0; ridx_d = '0;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_SACK: begin
          if (scl_fall) begin
            bit_d = 4'd0; aack_d = 1'b0;
            if (aack_q && rw_q) begin
              tx_d = CNT_BYTE; oe_d = ~CNT_BYTE[7]; st_d = ST_RD;
            end else begin
              oe_d = 1'b0; st_d = ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            sh_d = {sh_q[6:0], sda_s}; bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            we = (wcnt_q >= WC_DUM) && (wcnt_q < WC_MAX);
            if (wcnt_q != WC_MAX) wcnt_d = wcnt_q + 1'b1;
            oe_d = 1'b1; st_d = ST_SACK;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bit_d = bit_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_q == 4'd8) begin
              oe_d = 1'b0; st_d = ST_MACK;
            end else begin
              tx_d = {tx_q[6:0], 1'b0}; oe_d = ~tx_q[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_d = rd_byte; oe_d = ~rd_byte[7]; bit_d = 4'd0; st_d = ST_RD;
              if (ridx_q != IDX_LST) ridx_d = ridx_q + 1'b1;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q <= ST_IDLE; bit_q <= '0; sh_q <= '0; tx_q <= '0; oe_q <= 1'b0;
      rw_q <= 1'b0; aack_q <= 1'b0; mack_q <= 1'b0; wcnt_q <= '0;
      ridx_q <= '0; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      st_q <= st_d; bit_q <= bit_d; sh_q <= sh_d; tx_q <= tx_d; oe_q <= oe_d;
      rw_q <= rw_d; aack_q <= aack_d; mack_q <= mack_d; wcnt_q <= wcnt_d;
      ridx_q <= ridx_d; scl_d <= scl_s; sda_d <= sda_s;
    end
  end

  cfgi2c_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .we_i(we), .widx_i(wrel[IDXW-1:0]),
    .wdata_i(sh_q), .q_o(cfg_o)
  );

  assign sda_oe = oe_q;

  // R1
  addr_miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_ADDR && scl_fall && bit_q == 4'd8 && sh_q[7:1] != DEV_ADDR
     && !bus_start && !bus_stop) |=> !sda_oe);
  // R10
  byte_ack_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_WR && scl_fall && bit_q == 4'd8 && !bus_start && !bus_stop)
    |=> sda_oe);
  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !we |=> $stable(cfg_o));
  // R9
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_MACK && scl_fall && !mack_q && !bus_start && !bus_stop)
    |=> (!sda_oe && st_q == ST_IDLE));
  // R11
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(oe_q) |-> !scl_s);
endmodule

// File: tb/cfgi2c_slave_bench.sv
module cfgi2c_slave_bench;
  localparam int Q = 8;
  localparam int NV = 4;
  // {number of data bytes after the two dummies, up to 8 data bytes}
  localparam logic [67:0] VEC [NV] = '{
    {4'd6, 64'h1122334455660000},
    {4'd2, 64'hA1B2000000000000},
    {4'd8, 64'h0102030405060708},
    {4'd0, 64'h0000000000000000}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [47:0] cfg_o;
  wire sda_line = sda_m & ~sda_oe;
  int checks = 0, errors = 0, r11_viol = 0;
  logic [7:0] exp_r [6];

  always #10 clk = ~clk;

  cfgi2c_slave u_cfgi2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_o(cfg_o)
  );

  logic oe_prev = 1'b0;
  always @(posedge clk) begin
    if (sda_oe && !oe_prev && scl) r11_viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic bstart();
    sda_m = 1'b1; scl = 1'b1; qw(); sda_m = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic bstop();
    sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
    end
    sda_m = 1'b1; qw(); scl = 1'b1; qw(); ack = ~sda_line; qw(); scl = 1'b0; qw();
  endtask

  task automatic recv(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl = 1'b1; qw(); b[i] = sda_line; qw(); scl = 1'b0;
    end
    qw(); sda_m = ~give_ack; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
    sda_m = 1'b1;
  endtask

  function automatic logic [47:0] model();
    logic [47:0] m;
    for (int k = 0; k < 6; k++) m[8*k +: 8] = exp_r[k];
    return m;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack, all_ack;
    logic [7:0] b;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    exp_r[0] = 8'h00;
    for (int k = 1; k < 6; k++) exp_r[k] = 8'hFF;
    chk("R6 reset values", {16'h0, cfg_o}, {16'h0, 48'hFFFFFFFFFF00});
    chk("R6 sda idle", {63'h0, sda_oe}, 64'h0);

    // table of block writes
    for (int v = 0; v < NV; v++) begin
      int n = int'(VEC[v][67:64]);
      all_ack = 1'b1;
      bstart();
      send(8'hD2, ack); all_ack &= ack;
      send(8'h3C, ack); all_ack &= ack;   // command dummy (R2)
      send(8'h09, ack); all_ack &= ack;   // count dummy (R2)
      for (int i = 0; i < n; i++) begin
        logic [7:0] d = VEC[v][63-8*i -: 8];
        send(d, ack); all_ack &= ack;
        if (i < 6) exp_r[i] = d;          // R3, R5
      end
      bstop();
      repeat (4) @(negedge clk);
      chk("R10 all bytes acknowledged", {63'h0, all_ack}, 64'h1);
      chk("R2 R3 R4 R5 registers after write", {16'h0, cfg_o}, {16'h0, model()});
    end

    // wrong address: no ack, no effect
    bstart();
    send(8'hA4, ack);
    chk("R1 foreign address not acknowledged", {63'h0, ack}, 64'h0);
    send(8'h00, ack); send(8'h00, ack); send(8'h5A, ack);
    chk("R1 no ack on later bytes", {63'h0, ack}, 64'h0);
    bstop();
    repeat (4) @(negedge clk);
    chk("R1 registers unchanged", {16'h0, cfg_o}, {16'h0, model()});

    // block read
    bstart();
    send(8'hD3, ack);
    chk("R1 read address acknowledged", {63'h0, ack}, 64'h1);
    recv(1'b1, b);
    chk("R7 byte count first", {56'h0, b}, 64'h06);
    for (int k = 0; k < 6; k++) begin
      recv(1'b1, b);
      chk("R7 register in order", {56'h0, b}, {56'h0, exp_r[k]});
    end
    recv(1'b1, b);
    chk("R8 pointer holds at last", {56'h0, b}, {56'h0, exp_r[5]});
    recv(1'b0, b);
    chk("R8 last register repeated", {56'h0, b}, {56'h0, exp_r[5]});
    recv(1'b0, b);
    chk("R9 released after nack", {56'h0, b}, 64'hFF);
    chk("R9 sda not driven", {63'h0, sda_oe}, 64'h0);
    bstop();

    // fresh write after nack still works
    bstart();
    send(8'hD2, ack); send(8'h00, ack); send(8'h00, ack); send(8'h77, ack);
    bstop();
    exp_r[0] = 8'h77;
    repeat (4) @(negedge clk);
    chk("R4 R3 short write after read", {16'h0, cfg_o}, {16'h0, model()});
    chk("R11 no drive start while scl high", 64'(r11_viol), 64'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule